// File: doc/BRIEF.md
# Exception Restart-Address Capture with Delay-Slot Correction

This block sits at the commit point of an in-order pipeline that has one delay slot after each branch. For every committing instruction it receives the instruction's address, a flag that says the instruction occupies a delay slot, and the address of the branch ahead of it. It also receives a synchronous exception request and an asynchronous interrupt request. When either request is accepted, the block records a restart address, a delay-slot status bit and a bit that says whether an interrupt caused the entry. In the next cycle it pulses a flush for all younger in-flight work.

The restart address must not point at a delay-slot instruction. Resuming there would skip the branch, so a taken branch would act as not taken. For a faulting delay-slot instruction the block therefore saves the branch's address and sets the status bit. On resume the branch is evaluated again and reaches the same outcome, and then its delay slot runs again. A committing return operation asks fetch to restart at the saved address.

Top module: `exc_restart_capture`

## Requirements
- R1: After reset, the saved address is 0, and the delay-slot bit, the interrupt-cause bit, `flush` and `resume_valid` are all 0.
- R2: An accepted request on an instruction that is not in a delay slot sets `saved_pc` to that instruction's address and clears `in_slot_flag`. Both values are visible on the cycle after the commit.
- R3: An accepted request on a delay-slot instruction sets `saved_pc` to `cm_branch_pc`, the address of the branch before it (the slot's address minus 4), and sets `in_slot_flag`. This holds whether the branch was taken or not.
- R4: An interrupt accepted at a delay-slot instruction follows the same rule as R3, and `by_irq` is set to 1.
- R5: A request is accepted only while `cm_valid` is 1 and `flush` is 0. When both `exc_req` and `irq_req` are 1, the synchronous exception wins and `by_irq` is 0.
- R6: An acceptance raises `flush` for exactly one cycle, on the cycle after the commit. Requests and returns presented while `flush` is 1 are ignored.
- R7: When no request is accepted, `saved_pc`, `in_slot_flag` and `by_irq` hold their values, including across ordinary commits and requests that arrive with `cm_valid` at 0.
- R8: A return accepted while `cm_valid` is 1 and `flush` is 0 raises `resume_valid` for one cycle, on the cycle after the commit, with `resume_pc` equal to `saved_pc`. A return that coincides with an accepted request produces no resume pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cm_valid | input | 1 | An instruction commits this cycle |
| cm_pc | input | PC_W | Address of the committing instruction |
| cm_in_slot | input | 1 | Committing instruction sits in a delay slot |
| cm_branch_pc | input | PC_W | Address of the branch preceding the committing instruction |
| exc_req | input | 1 | Synchronous exception raised by the committing instruction |
| irq_req | input | 1 | Pending asynchronous interrupt |
| ret_req | input | 1 | Committing instruction is a return-from-exception |
| saved_pc | output | PC_W | Saved restart address |
| in_slot_flag | output | 1 | Last accepted request hit a delay-slot instruction |
| by_irq | output | 1 | Last accepted request was an interrupt |
| flush | output | 1 | One-cycle flush of younger in-flight instructions |
| resume_valid | output | 1 | One-cycle fetch redirect for a return |
| resume_pc | output | PC_W | Fetch redirect target |

## Verification
The hardest case to reach is a fault on a delay-slot instruction whose branch was taken. Correct handling then shows up only when the pipeline returns and re-executes the branch. The bench places a branch and its slot at chosen addresses and faults the slot once after a taken outcome and once after a not-taken outcome. It then commits a return and checks that the redirect lands on the branch, not on the slot or the target. It also raises requests in the cycle straight after an acceptance, while the flush is still high, so that the blocking of requests during a flush is exercised.

// File: rtl/exc_restart_capture.sv
module exc_restart_capture #(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cm_valid,
  input  logic [PC_W-1:0] cm_pc,
  input  logic            cm_in_slot,
  input  logic [PC_W-1:0] cm_branch_pc,
  input  logic            exc_req,
  input  logic            irq_req,
  input  logic            ret_req,
  output logic [PC_W-1:0] saved_pc,
  output logic            in_slot_flag,
  output logic            by_irq,
  output logic            flush,
  output logic            resume_valid,
  output logic [PC_W-1:0] resume_pc
);

  logic live;
  logic take;
  logic do_ret;

  assign live   = cm_valid && !flush;
  assign take   = live && (exc_req || irq_req);
  assign do_ret = live && ret_req && !take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      saved_pc     <= '0;
      in_slot_flag <= 1'b0;
      by_irq       <= 1'b0;
      flush        <= 1'b0;
      resume_valid <= 1'b0;
    end else begin
      flush        <= take;
      resume_valid <= do_ret;
      if (take) begin
        saved_pc     <= cm_in_slot ? cm_branch_pc : cm_pc;
        in_slot_flag <= cm_in_slot;
        by_irq       <= !exc_req;
      end
    end
  end

  assign resume_pc = saved_pc;

endmodule

module exc_restart_capture_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cm_valid,
  input logic [PC_W-1:0] cm_pc,
  input logic            cm_in_slot,
  input logic [PC_W-1:0] cm_branch_pc,
  input logic            exc_req,
  input logic            irq_req,
  input logic            ret_req,
  input logic [PC_W-1:0] saved_pc,
  input logic            in_slot_flag,
  input logic            by_irq,
  input logic            flush,
  input logic            resume_valid,
  input logic [PC_W-1:0] resume_pc
);

  a_r2_own_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid && !flush && (exc_req || irq_req) && !cm_in_slot)
      |=> (saved_pc == $past(cm_pc) && !in_slot_flag));

  a_r3_branch_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid && !flush && (exc_req || irq_req) && cm_in_slot)
      |=> (saved_pc == $past(cm_branch_pc) && in_slot_flag));

  a_r5_sync_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid && !flush && exc_req) |=> !by_irq);

  a_r6_flush_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !flush);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(cm_valid && !flush && (exc_req || irq_req))
      |=> ($stable(saved_pc) && $stable(in_slot_flag) && $stable(by_irq)));

  a_r8_resume: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid && !flush && ret_req && !exc_req && !irq_req)
      |=> (resume_valid && resume_pc == $past(saved_pc)));

endmodule

bind exc_restart_capture exc_restart_capture_chk #(.PC_W(PC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cm_valid(cm_valid), .cm_pc(cm_pc),
  .cm_in_slot(cm_in_slot), .cm_branch_pc(cm_branch_pc),
  .exc_req(exc_req), .irq_req(irq_req), .ret_req(ret_req),
  .saved_pc(saved_pc), .in_slot_flag(in_slot_flag), .by_irq(by_irq),
  .flush(flush), .resume_valid(resume_valid), .resume_pc(resume_pc)
);

// File: tb/exc_restart_capture_tb_top.sv
module exc_restart_capture_tb_top;
  localparam int PC_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cm_valid = 1'b0, cm_in_slot = 1'b0;
  logic exc_req = 1'b0, irq_req = 1'b0, ret_req = 1'b0;
  logic [PC_W-1:0] cm_pc = '0, cm_branch_pc = '0;
  logic [PC_W-1:0] saved_pc, resume_pc;
  logic in_slot_flag, by_irq, flush, resume_valid;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  exc_restart_capture #(.PC_W(PC_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cm_valid(cm_valid), .cm_pc(cm_pc),
    .cm_in_slot(cm_in_slot), .cm_branch_pc(cm_branch_pc),
    .exc_req(exc_req), .irq_req(irq_req), .ret_req(ret_req),
    .saved_pc(saved_pc), .in_slot_flag(in_slot_flag), .by_irq(by_irq),
    .flush(flush), .resume_valid(resume_valid), .resume_pc(resume_pc)
  );

  task automatic chk(string req, logic [PC_W-1:0] act, logic [PC_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    cm_valid = 0; exc_req = 0; irq_req = 0; ret_req = 0; cm_in_slot = 0;
  endtask

  // drive one commit at a negedge; return at the next negedge (one posedge later)
  task automatic commit(logic [PC_W-1:0] pc, logic slot, logic ex, logic ir, logic rt);
    cm_valid = 1; cm_pc = pc; cm_in_slot = slot; cm_branch_pc = pc - 4;
    exc_req = ex; irq_req = ir; ret_req = rt;
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    chk("R1 saved_pc", saved_pc, '0);
    chk("R1 in_slot_flag", {31'b0, in_slot_flag}, 0);
    chk("R1 by_irq", {31'b0, by_irq}, 0);
    chk("R1 flush", {31'b0, flush}, 0);
    chk("R1 resume_valid", {31'b0, resume_valid}, 0);
  endtask

  task automatic t_plain_fault();
    commit(32'h0000_1000, 0, 1, 0, 0);
    chk("R2 saved_pc", saved_pc, 32'h0000_1000);
    chk("R2 in_slot_flag", {31'b0, in_slot_flag}, 0);
    chk("R6 flush high", {31'b0, flush}, 1);
    @(negedge clk);
    chk("R6 flush one cycle", {31'b0, flush}, 0);
  endtask

  // branch at br; taken goes to tgt; slot at br+4 faults either way
  task automatic t_slot_fault(logic [PC_W-1:0] br, bit taken);
    commit(br, 0, 0, 0, 0);
    commit(br + 4, 1, 1, 0, 0);
    chk(taken ? "R3 taken saved_pc" : "R3 nottaken saved_pc", saved_pc, br);
    chk("R3 in_slot_flag", {31'b0, in_slot_flag}, 1);
    @(negedge clk);
    commit(32'h8000_0180, 0, 0, 0, 1);
    chk("R8 resume_valid", {31'b0, resume_valid}, 1);
    chk("R8 resume_pc is branch", resume_pc, br);
    @(negedge clk);
    chk("R8 resume one cycle", {31'b0, resume_valid}, 0);
  endtask

  task automatic t_irq_slot();
    commit(32'h0000_2004, 1, 0, 1, 0);
    chk("R4 saved_pc", saved_pc, 32'h0000_2000);
    chk("R4 in_slot_flag", {31'b0, in_slot_flag}, 1);
    chk("R4 by_irq", {31'b0, by_irq}, 1);
    @(negedge clk);
  endtask

  task automatic t_both();
    commit(32'h0000_3000, 0, 1, 1, 0);
    chk("R5 by_irq sync wins", {31'b0, by_irq}, 0);
    chk("R5 saved_pc", saved_pc, 32'h0000_3000);
    @(negedge clk);
  endtask

  task automatic t_ignored();
    cm_valid = 0; exc_req = 1; irq_req = 1; cm_pc = 32'h0000_9990;
    @(negedge clk);
    idle();
    chk("R5 no commit no accept", saved_pc, 32'h0000_3000);
    chk("R5 no flush", {31'b0, flush}, 0);
    commit(32'h0000_4444, 0, 0, 0, 0);
    commit(32'h0000_4448, 1, 0, 0, 0);
    chk("R7 hold across commits", saved_pc, 32'h0000_3000);
    chk("R7 slot bit held", {31'b0, in_slot_flag}, 0);
  endtask

  task automatic t_during_flush();
    commit(32'h0000_5000, 0, 1, 0, 0);
    chk("R6 flush raised", {31'b0, flush}, 1);
    commit(32'h0000_5104, 1, 1, 0, 1);
    chk("R6 request during flush ignored", saved_pc, 32'h0000_5000);
    chk("R6 return during flush ignored", {31'b0, resume_valid}, 0);
    chk("R6 no second flush", {31'b0, flush}, 0);
  endtask

  task automatic t_ret_collide();
    commit(32'h0000_6000, 0, 1, 0, 1);
    chk("R8 collision no resume", {31'b0, resume_valid}, 0);
    chk("R8 collision saved", saved_pc, 32'h0000_6000);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_plain_fault();
    t_slot_fault(32'h0000_0100, 1);
    t_slot_fault(32'h0FFF_FFFC, 0);
    t_irq_slot();
    t_both();
    t_ignored();
    t_during_flush();
    t_ret_collide();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule